// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block makes up to four serial flash devices appear as one linear, read-only address window. Each chip select owns a fixed 16 MiB slice of the window. The chip is picked from the offset bits above the slice, and the bits inside the slice form the flash address. A host read is served by one serial read frame. The frame carries the standard single-lane read opcode and a 3-byte address, rounded down to the burst boundary. The bridge then fetches a whole burst and returns it to the host as one line, with the lowest-addressed byte in the lowest byte lane.

Two configuration inputs limit the window, both counted in 512 KiB units. One sets the total populated size and the other sets the populated size of each chip. A read that falls outside either limit never reaches the serial bus and returns all-ones. A stall input lets a register-driven command engine take over the serial bus. While stall is high, no new mapped read is accepted. A read that has already opened its frame runs to completion.

Top module: `flash_window_bridge`

## Requirements
- R1: The chip select driven low is `spi_cs_n[rd_addr[25:24]]`, and at most one chip select is low at any time.
- R2: Each frame sends opcode 0x03 and then three address bytes, most significant first, all bits MSB first. The address is `rd_addr[23:0]` with its low 4 bits cleared.
- R3: `rd_data` byte lane i (bits 8i+7:8i) holds the flash byte at the aligned address plus i, for i = 0..15, read with 16 data bytes per frame.
- R4: A read whose offset is at or above `cfg_total_units` x 512 KiB drives no chip select and completes with `rd_data` all ones.
- R5: A read whose slice offset `rd_addr[23:0]` is at or above `cfg_chip_units` x 512 KiB drives no chip select and completes with `rd_data` all ones.
- R6: While `stall_host` is high, no new read is accepted: no chip select goes low and `rd_ready` stays low until stall is released.
- R7: A stall raised after a frame has opened does not interrupt it. The frame completes and returns correct data.
- R8: After reset all chip selects are high, `spi_sclk` is low and `rd_ready` is low.
- R9: The serial clock idles low whenever no chip select is active (mode 0: data changes on the falling edge and is sampled on the rising edge).
- R10: `rd_ready` is a single-cycle pulse, and each accepted request produces exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Host read request, held until `rd_ready` |
| rd_addr | input | 26 | Byte offset into the window |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 128 | Returned burst line, lowest address in bits 7:0 |
| stall_host | input | 1 | Blocks acceptance of new mapped reads |
| cfg_total_units | input | 8 | Populated window size in 512 KiB units |
| cfg_chip_units | input | 8 | Populated size per chip in 512 KiB units |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 4 | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
If the frame sequencer loses track of its byte index, the next read shows it. The header seen by the flash model carries the wrong opcode or address byte, or the returned line has its byte lanes rotated. If the range decode is wrong, a chip select appears on a read that should be refused, or a line of all ones comes back where real data was expected, both within one request. A fault in the stall gate shows as a chip select falling during the stall hold window, long before the stall is released. A fault in the bit engine corrupts every byte of the first line read after reset.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int SLICE_BITS  = 24;
    localparam int UNIT_SHIFT  = 19;
    localparam logic [7:0] READ_OPCODE = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA
    } fw_state_e;
endpackage

// File: rtl/fw_decode.sv
module fw_decode #(
    parameter int CS_BITS  = 2,
    parameter int CFG_W    = 8,
    parameter int LINE_LSB = 4,
    localparam int SLICE_BITS = fw_pkg::SLICE_BITS,
    localparam int OFF_W      = CS_BITS + SLICE_BITS
) (
    input  logic [OFF_W-1:0]      offset,
    input  logic [CFG_W-1:0]      total_units,
    input  logic [CFG_W-1:0]      chip_units,
    output logic [CS_BITS-1:0]    cs_idx,
    output logic [SLICE_BITS-1:0] flash_addr,
    output logic                  in_range
);
    localparam int LIM_W = CFG_W + fw_pkg::UNIT_SHIFT;
    localparam int CMP_W = ((OFF_W > LIM_W) ? OFF_W : LIM_W) + 1;

    logic [CMP_W-1:0] total_lim;
    logic [CMP_W-1:0] chip_lim;
    logic [CMP_W-1:0] off_ext;
    logic [CMP_W-1:0] slice_ext;

    always_comb begin
        total_lim  = CMP_W'(total_units) << fw_pkg::UNIT_SHIFT;
        chip_lim   = CMP_W'(chip_units) << fw_pkg::UNIT_SHIFT;
        off_ext    = CMP_W'(offset);
        slice_ext  = CMP_W'(offset[SLICE_BITS-1:0]);
        cs_idx     = offset[OFF_W-1:SLICE_BITS];
        flash_addr = {offset[SLICE_BITS-1:LINE_LSB], {LINE_LSB{1'b0}}};
        in_range   = (off_ext < total_lim) && (slice_ext < chip_lim);
    end
endmodule

// File: rtl/fw_spi_byte.sv
module fw_spi_byte #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic          done;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic [3:0]    bits;
        logic [CW-1:0] cnt;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy = 1'b1;
                eng_d.sh   = tx_byte;
                eng_d.bits = 4'd8;
                eng_d.cnt  = CW'(HALF - 1);
                eng_d.sclk = 1'b0;
            end
        end else if (eng_q.cnt != '0) begin
            eng_d.cnt = eng_q.cnt - 1'b1;
        end else begin
            eng_d.cnt = CW'(HALF - 1);
            if (!eng_q.sclk) begin
                eng_d.sclk = 1'b1;
                eng_d.rx   = {eng_q.rx[6:0], miso};
            end else begin
                eng_d.sclk = 1'b0;
                if (eng_q.bits == 4'd1) begin
                    eng_d.busy = 1'b0;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.bits = eng_q.bits - 1'b1;
                    eng_d.sh   = {eng_q.sh[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign done    = eng_q.done;
    assign rx_byte = eng_q.rx;
    assign sclk    = eng_q.sclk;
    assign mosi    = eng_q.sh[7];
endmodule

// File: rtl/fw_line_buf.sv
module fw_line_buf #(
    parameter int BYTES = 16,
    localparam int IW = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic             fill_ones,
    output logic [8*BYTES-1:0] line
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (fill_ones)                           lane_d = 8'hFF;
            else if (wr_en && wr_idx == IW'(g))      lane_d = wr_byte;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign line[8*g +: 8] = lane_q;
    end
endmodule

// File: rtl/flash_window_bridge.sv
module flash_window_bridge #(
    parameter int NUM_CS      = 4,
    parameter int BURST_BYTES = 16,
    parameter int SCLK_HALF   = 2,
    parameter int CFG_W       = 8,
    localparam int CS_BITS    = $clog2(NUM_CS),
    localparam int OFF_W      = CS_BITS + fw_pkg::SLICE_BITS,
    localparam int LINE_LSB   = $clog2(BURST_BYTES),
    localparam int LINE_W     = 8 * BURST_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [OFF_W-1:0]  rd_addr,
    output logic              rd_ready,
    output logic [LINE_W-1:0] rd_data,
    input  logic              stall_host,
    input  logic [CFG_W-1:0]  cfg_total_units,
    input  logic [CFG_W-1:0]  cfg_chip_units,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    import fw_pkg::*;

    localparam int IDX_W = LINE_LSB;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_BYTES - 1);

    typedef struct packed {
        fw_state_e             state;
        logic [NUM_CS-1:0]     cs_n;
        logic [SLICE_BITS-1:0] faddr;
        logic [IDX_W-1:0]      idx;
        logic                  start;
        logic [7:0]            tx;
        logic                  ready;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CS_BITS-1:0]    dec_cs;
    logic [SLICE_BITS-1:0] dec_faddr;
    logic                  dec_in_range;
    logic                  eng_done;
    logic [7:0]            eng_rx;
    logic                  wr_en;
    logic                  fill_ones;

    fw_decode #(
        .CS_BITS  (CS_BITS),
        .CFG_W    (CFG_W),
        .LINE_LSB (LINE_LSB)
    ) u_decode (
        .offset      (rd_addr),
        .total_units (cfg_total_units),
        .chip_units  (cfg_chip_units),
        .cs_idx      (dec_cs),
        .flash_addr  (dec_faddr),
        .in_range    (dec_in_range)
    );

    fw_spi_byte #(
        .HALF (SCLK_HALF)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ctl_q.start),
        .tx_byte (ctl_q.tx),
        .miso    (spi_miso),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    fw_line_buf #(
        .BYTES (BURST_BYTES)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ctl_q.idx),
        .wr_byte   (eng_rx),
        .fill_ones (fill_ones),
        .line      (rd_data)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.ready = 1'b0;
        wr_en       = 1'b0;
        fill_ones   = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (rd_req && !stall_host && !ctl_q.ready) begin
                    if (dec_in_range) begin
                        ctl_d.state = ST_CMD;
                        ctl_d.cs_n  = ~(NUM_CS'(1) << dec_cs);
                        ctl_d.faddr = dec_faddr;
                        ctl_d.start = 1'b1;
                        ctl_d.tx    = READ_OPCODE;
                    end else begin
                        fill_ones   = 1'b1;
                        ctl_d.ready = 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (eng_done) begin
                    ctl_d.state = ST_ADDR;
                    ctl_d.idx   = '0;
                    ctl_d.start = 1'b1;
                    ctl_d.tx    = ctl_q.faddr[23:16];
                end
            end
            ST_ADDR: begin
                if (eng_done) begin
                    ctl_d.start = 1'b1;
                    if (ctl_q.idx == IDX_W'(2)) begin
                        ctl_d.state = ST_DATA;
                        ctl_d.idx   = '0;
                        ctl_d.tx    = 8'h00;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                        ctl_d.tx  = (ctl_q.idx == '0) ? ctl_q.faddr[15:8]
                                                      : ctl_q.faddr[7:0];
                    end
                end
            end
            ST_DATA: begin
                if (eng_done) begin
                    wr_en = 1'b1;
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.cs_n  = '1;
                        ctl_d.ready = 1'b1;
                    end else begin
                        ctl_d.idx   = ctl_q.idx + 1'b1;
                        ctl_d.start = 1'b1;
                        ctl_d.tx    = 8'h00;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.cs_n  <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign spi_cs_n = ctl_q.cs_n;
    assign rd_ready = ctl_q.ready;
endmodule

// File: rtl/fw_checks.sv
module fw_checks #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              spi_sclk,
    input logic              rd_ready,
    input logic              stall_host
);
    // R1: never more than one device selected
    a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R9: clock parked low outside a frame
    a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> !spi_sclk);

    // R10: completion is one cycle wide
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    // R6: a stall seen with the bus free keeps the bus free next cycle
    a_r6_stall_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_host && (&spi_cs_n)) |=> (&spi_cs_n));

    // R7: a frame in flight is not cut short by stall
    a_r7_frame_survives_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_host && !(&spi_cs_n) && !spi_sclk && $stable(spi_cs_n) && !rd_ready)
        |=> ((spi_cs_n == $past(spi_cs_n)) || rd_ready));
endmodule

bind flash_window_bridge fw_checks #(.NUM_CS(NUM_CS)) u_fw_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .rd_ready   (rd_ready),
    .stall_host (stall_host)
);

// File: tb/flash_window_bridge_test.sv
module flash_window_bridge_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req = 1'b0;
    logic [25:0]  rd_addr = '0;
    logic         rd_ready;
    logic [127:0] rd_data;
    logic         stall_host = 1'b0;
    logic [7:0]   cfg_total_units = 8'd128;
    logic [7:0]   cfg_chip_units = 8'd32;
    logic         spi_sclk;
    logic [3:0]   spi_cs_n;
    logic         spi_mosi;
    logic         spi_miso = 1'b0;

    int vectors = 0;
    int misses = 0;

    always #10 clk = ~clk;

    flash_window_bridge uut (
        .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_ready (rd_ready), .rd_data (rd_data), .stall_host (stall_host),
        .cfg_total_units (cfg_total_units), .cfg_chip_units (cfg_chip_units),
        .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    // ---------------- flash model ----------------
    int          rise_cnt = 0;
    int          frames = 0;
    int          sel = 0;
    logic [31:0] hdr = '0;

    function automatic logic [7:0] fbyte(int c, logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ (8'h5A + 8'(c));
    endfunction

    always @(spi_cs_n) begin
        if (spi_cs_n == 4'hF) begin
            rise_cnt = 0;
        end else begin
            frames++;
            rise_cnt = 0;
            for (int k = 0; k < 4; k++) if (!spi_cs_n[k]) sel = k;
        end
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n != 4'hF) begin
            if (rise_cnt < 32) hdr = {hdr[30:0], spi_mosi};
            rise_cnt++;
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_cs_n != 4'hF && rise_cnt >= 32) begin
            int j;
            logic [7:0] b;
            j = rise_cnt - 32;
            b = fbyte(sel, hdr[23:0] + 24'(j / 8));
            spi_miso = b[7 - (j % 8)];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_line(int c, logic [23:0] off);
        logic [127:0] l;
        logic [23:0] base;
        base = {off[23:4], 4'h0};
        for (int i = 0; i < 16; i++) l[8*i +: 8] = fbyte(c, base + 24'(i));
        return l;
    endfunction

    task automatic host_read(logic [25:0] off, output logic [127:0] data, output bit ok);
        int n;
        @(negedge clk);
        rd_addr = off;
        rd_req  = 1'b1;
        n = 0;
        ok = 1'b0;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if (rd_ready) begin
                ok = 1'b1;
                break;
            end
        end
        data   = rd_data;
        rd_req = 1'b0;
        if (!ok) chk("R10 timeout", 128'd0, 128'd1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk("R8 cs_n", 128'(spi_cs_n), 128'hF);
        chk("R8 sclk", 128'(spi_sclk), 128'h0);
        chk("R8 ready", 128'(rd_ready), 128'h0);
    endtask

    task automatic t_mapped(logic [25:0] off);
        logic [127:0] d;
        bit ok;
        int f0;
        f0 = frames;
        host_read(off, d, ok);
        chk("R1 selected chip", 128'(sel), 128'(off[25:24]));
        chk("R2 opcode", 128'(hdr[31:24]), 128'h03);
        chk("R2 aligned address", 128'(hdr[23:0]), 128'({off[23:4], 4'h0}));
        chk("R3 line data", d, exp_line(int'(off[25:24]), off[23:0]));
        chk("R10 one frame per read", 128'(frames - f0), 128'd1);
        @(negedge clk);
        chk("R10 ready one cycle", 128'(rd_ready), 128'h0);
    endtask

    task automatic t_total_limit();
        logic [127:0] d;
        bit ok;
        int f0;
        cfg_total_units = 8'd64;
        f0 = frames;
        host_read(26'h2000040, d, ok);
        chk("R4 all-ones data", d, {128{1'b1}});
        chk("R4 no chip select", 128'(frames - f0), 128'd0);
        t_mapped(26'h1FFFFF7);
        cfg_total_units = 8'd128;
    endtask

    task automatic t_chip_limit();
        logic [127:0] d;
        bit ok;
        int f0;
        cfg_chip_units = 8'd8;
        f0 = frames;
        host_read(26'h0400000, d, ok);
        chk("R5 all-ones data", d, {128{1'b1}});
        chk("R5 no chip select", 128'(frames - f0), 128'd0);
        t_mapped(26'h03FFFF0);
        cfg_chip_units = 8'd32;
    endtask

    task automatic t_stall_idle();
        logic [127:0] d;
        bit ok;
        bit seen_cs, seen_rdy;
        int n;
        stall_host = 1'b1;
        @(negedge clk);
        rd_addr = 26'h1234567;
        rd_req  = 1'b1;
        seen_cs = 0;
        seen_rdy = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (spi_cs_n != 4'hF) seen_cs = 1;
            if (rd_ready) seen_rdy = 1;
        end
        chk("R6 no select while stalled", 128'(seen_cs), 128'd0);
        chk("R6 no ready while stalled", 128'(seen_rdy), 128'd0);
        stall_host = 1'b0;
        n = 0;
        ok = 0;
        while (n < 20000 && !ok) begin
            @(negedge clk);
            n++;
            if (rd_ready) ok = 1;
        end
        d = rd_data;
        rd_req = 1'b0;
        chk("R6 completes after release", 128'(ok), 128'd1);
        chk("R6 data after release", d, exp_line(1, 24'h234567));
    endtask

    task automatic t_stall_mid();
        logic [127:0] d;
        bit ok;
        int n;
        @(negedge clk);
        rd_addr = 26'h3ABCDEF;
        rd_req  = 1'b1;
        n = 0;
        while (spi_cs_n == 4'hF && n < 200) begin
            @(negedge clk);
            n++;
        end
        stall_host = 1'b1;
        n = 0;
        ok = 0;
        while (n < 20000 && !ok) begin
            @(negedge clk);
            n++;
            if (rd_ready) ok = 1;
        end
        d = rd_data;
        rd_req = 1'b0;
        chk("R7 frame finishes under stall", 128'(ok), 128'd1);
        chk("R7 data under stall", d, exp_line(3, 24'hABCDEF));
        chk("R7 header under stall", 128'(hdr), 128'h03ABCDE0);
        @(negedge clk);
        chk("R9 clock idle after frame", 128'(spi_sclk), 128'd0);
        stall_host = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_mapped(26'h0000000);
        t_mapped(26'h0123459);
        t_mapped(26'h1FEDCBA);
        t_mapped(26'h2800011);
        t_mapped(26'h3FFFFFF);
        t_total_limit();
        t_chip_limit();
        t_stall_idle();
        t_stall_mid();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule